// File: doc/BRIEF.md
# Ripple Carry Arithmetic Slice

This block is an eight-bit arithmetic slice whose carry travels bit by bit along a chain of multiplexers. At each bit position the two operand bits produce a propagate term (their XOR) and a generate term (their AND). When propagate is true, the incoming carry passes on to the next bit. When it is false, the generate term becomes the carry. Each sum bit is the propagate term XORed with the carry that arrives at that position.

A mode input selects one of two uses:

- **Arithmetic use.** The slice adds or subtracts the two operand buses.
- **Count use.** The slice ignores both operand buses. It takes its own register contents as the first operand and steps that value up or down by one.

A single direction/operation pin `op_sel` serves both uses. In arithmetic use it picks add or subtract. In count use it picks up or down.

A half-width control shortens the chain to four bits. The slice then works on bits 3:0 only and takes the carry output from bit 3. The upper nibble of the register is frozen.

The register has a synchronous reset, a clock enable and a synchronous parallel load. The load takes priority over the arithmetic update, and it is also how a count is given its start value.

Top module: `ripple_arith_slice`

## Requirements
- R1: Arithmetic use, add (`cnt_mode`=0, `op_sel`=1, `half_mode`=0): `{carry_out, sum_comb}` equals `opa + opb + carry_in` as a 9-bit value.
- R2: Arithmetic use, subtract (`op_sel`=0, `half_mode`=0): `sum_comb` = (`opa` − `opb`) mod 256, and `carry_out` is 1 exactly when `opa` ≥ `opb` (no borrow). `carry_in` has no effect.
- R3: Half width (`half_mode`=1) in arithmetic use: `sum_comb[3:0]` and `carry_out` follow R1 and R2 applied to the operand bits 3:0. `carry_out` is the carry out of bit 3. `sum_comb[7:4]` equals `sum_q[7:4]`, and operand bits 7:4 have no effect.
- R4: Count use, up (`cnt_mode`=1, `op_sel`=1): `sum_comb` = `sum_q` + 1, wrapping within the active width. `carry_out` is 1 exactly when the active bits of `sum_q` are all ones. `opa`, `opb` and `carry_in` have no effect.
- R5: Count use, down (`op_sel`=0): `sum_comb` = `sum_q` − 1, wrapping within the active width. `carry_out` is 0 exactly when the active bits of `sum_q` are all zero.
- R6: On a rising clock edge with `ce`=1 and `load`=0, `sum_q` takes the value `sum_comb` had before the edge.
- R7: On a rising edge with `ce`=1 and `load`=1, `sum_q` takes all eight bits of `load_data`, in either width and either use.
- R8: On a rising edge with `ce`=0, `sum_q` keeps its value.
- R9: A rising edge with `rst_n`=0 clears `sum_q` to zero, whatever `ce` and `load` are.
- R10: In half width, an update that is not a load leaves `sum_q[7:4]` unchanged, so a count wraps within bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| ce | input | 1 | Clock enable for the register |
| half_mode | input | 1 | 1 = four-bit chain ending at bit 3 |
| cnt_mode | input | 1 | 1 = count use, 0 = arithmetic use |
| op_sel | input | 1 | Arithmetic use: 1 add, 0 subtract. Count use: 1 up, 0 down |
| carry_in | input | 1 | Cascade carry into bit 0 (add only) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| load | input | 1 | Synchronous parallel load, qualified by `ce` |
| load_data | input | 8 | Parallel load value |
| sum_comb | output | 8 | Combinational result |
| sum_q | output | 8 | Registered result |
| carry_out | output | 1 | Carry out of the last active bit |

## Verification
`sum_comb` and `carry_out` are combinational. The bench therefore drives operands with the register idle (`ce`=0) and compares them one time unit later, in the same cycle. `sum_q` changes only at a rising edge, so each register result is sampled one time unit after the edge that captures it, never before. Inputs change only at those post-edge points, so no check depends on the order of events at the edge. Counter checks first load a start value in one edge and then compare the combinational step before the next edge.

// File: rtl/ripple_arith_slice.sv
module ripple_arith_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         half_mode,
  input  logic         cnt_mode,
  input  logic         op_sel,
  input  logic         carry_in,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] sum_comb,
  output logic [W-1:0] sum_q,
  output logic         carry_out
);
  localparam int HW = W / 2;

  logic [W-1:0] a_eff, b_eff, prop, gen, raw;
  logic [W:0]   chain;

  assign a_eff    = cnt_mode ? sum_q : opa;
  assign b_eff    = cnt_mode ? {W{~op_sel}} : (op_sel ? opb : ~opb);
  assign chain[0] = cnt_mode ? op_sel : (op_sel ? carry_in : 1'b1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop[i]      = a_eff[i] ^ b_eff[i];
    assign gen[i]       = a_eff[i] & b_eff[i];
    assign chain[i+1]   = prop[i] ? chain[i] : gen[i];
    assign raw[i]       = prop[i] ^ chain[i];
  end

  assign sum_comb  = half_mode ? {sum_q[W-1:HW], raw[HW-1:0]} : raw;
  assign carry_out = half_mode ? chain[HW] : chain[W];

  always_ff @(posedge clk) begin
    if (!rst_n)    sum_q <= '0;
    else if (ce)   sum_q <= load ? load_data : sum_comb;
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(sum_q));
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    ce && load |=> sum_q == $past(load_data));
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !load |=> sum_q == $past(sum_comb));
  a_r10_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !load && half_mode |=> sum_q[W-1:HW] == $past(sum_q[W-1:HW]));
  a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mode && op_sel && !half_mode |-> carry_out == (&sum_q));
  a_r5_borrow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mode && !op_sel && !half_mode |-> carry_out == (|sum_q));
endmodule

// File: tb/ripple_arith_slice_tb_top.sv
`timescale 1ns/1ps
module ripple_arith_slice_tb_top;
  logic clk = 0, rst_n = 0, ce = 0, half_mode = 0, cnt_mode = 0, op_sel = 1;
  logic carry_in = 0, load = 0;
  logic [7:0] opa = 0, opb = 0, load_data = 0;
  logic [7:0] sum_comb, sum_q;
  logic carry_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ripple_arith_slice #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .half_mode(half_mode),
    .cnt_mode(cnt_mode), .op_sel(op_sel), .carry_in(carry_in),
    .opa(opa), .opb(opb), .load(load), .load_data(load_data),
    .sum_comb(sum_comb), .sum_q(sum_q), .carry_out(carry_out));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_val(input logic [7:0] v);
    ce = 1; load = 1; load_data = v; tick(); ce = 0; load = 0;
  endtask

  initial begin
    #900000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp9;
    logic [7:0] v;
    // R9: reset clears, even with load requested
    ce = 1; load = 1; load_data = 8'h5A;
    tick(); tick();
    check("R9 reset", sum_q, 0);
    rst_n = 1; ce = 0; load = 0;

    // R1: exhaustive add
    half_mode = 0; cnt_mode = 0; op_sel = 1;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          opa = a[7:0]; opb = b[7:0]; carry_in = c[0]; #1;
          check("R1 add", {carry_out, sum_comb}, a + b + c);
        end

    // R2: exhaustive subtract, carry_in toggled to show it is ignored
    op_sel = 0;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        opa = a[7:0]; opb = b[7:0]; carry_in = a[0] ^ b[1]; #1;
        exp9 = ((a >= b) ? 256 : 0) + ((a - b) & 255);
        check("R2 sub", {carry_out, sum_comb}, exp9);
      end

    // R3: half width arithmetic, upper register nibble shows on sum_comb
    load_val(8'hA3);
    half_mode = 1;
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        for (int c = 0; c < 2; c++) begin
          opa = a[7:0]; opb = b[7:0]; carry_in = c[0];
          op_sel = 1; #1;
          exp9 = (a % 16) + (b % 16) + c;
          check("R3 half add", {carry_out, sum_comb},
                ((exp9 / 16) << 8) | 8'hA0 | (exp9 % 16));
          op_sel = 0; #1;
          exp9 = (((a % 16) >= (b % 16)) ? 256 : 0) | 8'hA0 | (((a % 16) - (b % 16)) & 15);
          check("R3 half sub", {carry_out, sum_comb}, exp9);
        end

    // R4 / R5: count from every start value, operands driven as noise
    half_mode = 0; cnt_mode = 1;
    for (int s = 0; s < 256; s++) begin
      load_val(s[7:0]);
      opa = ~s[7:0]; opb = s[7:0] ^ 8'h3C; carry_in = s[0];
      op_sel = 1; #1;
      check("R4 up", {carry_out, sum_comb}, ((s == 255) ? 256 : 0) + ((s + 1) & 255));
      op_sel = 0; #1;
      check("R5 down", {carry_out, sum_comb}, ((s != 0) ? 256 : 0) + ((s - 1) & 255));
    end
    half_mode = 1;
    for (int s = 0; s < 256; s += 7) begin
      load_val(s[7:0]);
      op_sel = 1; #1;
      check("R4 half up", {carry_out, sum_comb},
            (((s % 16) == 15) ? 256 : 0) + (s & 8'hF0) + (((s % 16) + 1) & 15));
      op_sel = 0; #1;
      check("R5 half down", {carry_out, sum_comb},
            (((s % 16) != 0) ? 256 : 0) + (s & 8'hF0) + (((s % 16) - 1) & 15));
    end

    // R6: registered counting across the wrap, full width
    half_mode = 0; op_sel = 1;
    load_val(8'hFA);
    v = 8'hFA;
    ce = 1;
    for (int k = 0; k < 10; k++) begin
      tick(); v = v + 1;
      check("R6 count up capture", sum_q, v);
    end
    op_sel = 0;
    for (int k = 0; k < 12; k++) begin
      tick(); v = v - 1;
      check("R6 count down capture", sum_q, v);
    end
    // R6: arithmetic capture
    cnt_mode = 0; op_sel = 1; opa = 8'h77; opb = 8'h99; carry_in = 1;
    tick();
    check("R6 add capture", sum_q, 8'h11);

    // R7: load wins over counting, all 8 bits even in half width
    cnt_mode = 1; half_mode = 1; load = 1; load_data = 8'hC6;
    tick();
    check("R7 load priority", sum_q, 8'hC6);
    load = 0;

    // R10: half width counting keeps bits 7:4 and wraps in bits 3:0
    v = 8'hC6; op_sel = 1;
    for (int k = 0; k < 20; k++) begin
      tick(); v = {v[7:4], v[3:0] + 4'd1};
      check("R10 half wrap", sum_q, v);
    end
    op_sel = 0;
    for (int k = 0; k < 20; k++) begin
      tick(); v = {v[7:4], v[3:0] - 4'd1};
      check("R10 half down wrap", sum_q, v);
    end

    // R8: disabled register ignores updates and loads
    ce = 0; load = 1; load_data = 8'h00;
    tick(); tick();
    check("R8 hold", sum_q, v);
    load = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule